// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block routes 24 interrupt input pins to interrupt messages. Software reaches its registers through a 32-bit register bus that has only two live offsets. Offset 0x00 is an index register. Offset 0x10 is a data window onto whichever internal register the index selects.

Behind the window are:
- an identification word, loaded at reset from a configuration input;
- a fixed, read-only version word;
- an arbitration word;
- a 24-entry redirection table. Each entry is 64 bits wide and is reached as two 32-bit halves.

A raise on an input pin is a single-cycle pulse. If the pin's entry is unmasked, the raise is recorded as pending. Pending pins are served lowest pin first. Each served pin produces one message on a valid/ready output, built from the entry's routing fields.

Input 0 never addresses entry 0. Its raise is steered onto pin 2 before the table is consulted. Two status bits in the low half of each entry belong to hardware, and software writes cannot change them.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset:
  - `msg_valid` is low.
  - The version word reads 0x00170011.
  - The arbitration word reads 0.
  - The identification word reads `cfg_id` placed in bits [27:24], with all other bits 0.
  - Every entry's low half reads 0x00010000 (mask bit 16 set) and its high half reads 0.
- R2: A write at bus offset 0x00 sets the 32-bit index, and a read at offset 0x00 returns it. Any offset other than 0x00 or 0x10 reads 0, and writes there change nothing.
- R3: Through the window at offset 0x10, the index selects the register as follows:
  - 0x00 selects the identification word.
  - 0x01 selects the version word.
  - 0x02 selects the arbitration word.
  - An index of 0x10 or above selects entry n = (index − 0x10) >> 1. An even offset selects the low half and an odd offset selects the high half.
- R4: The version word ignores writes. Writes to the identification word and the arbitration word take all 32 bits.
- R5: A write to an entry's low half leaves bits 12 and 14 (delivery status and remote-request status) unchanged and takes every other bit. A write to the high half takes all 32 bits.
- R6: An index that names an entry above 23, or an undefined index (0x03 to 0x0F), reads 0 through the window and ignores writes.
- R7: A raise on an unmasked pin produces exactly one message, assembled at the time the pin is served. The message fields come from the entry as follows:
  - vector = low bits [7:0]
  - delivery mode = low bits [10:8]
  - logical destination = low bit 11
  - trigger = low bit 15
  - destination = high bits [31:24]
  - shorthand is always 0

  A raise on a masked pin (low bit 16 = 1) produces no message.
- R8: A raise on input 0 is served as pin 2. If inputs 0 and 2 rise in the same cycle, they yield a single message.
- R9: When several pins are pending, messages leave in ascending pin order.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid` and every message field hold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_id | input | 4 | Identification value loaded into bits [27:24] at reset |
| bus_we | input | 1 | Register bus write strobe |
| bus_addr | input | 8 | Register bus byte offset |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data, combinational from `bus_addr` |
| irq_raise | input | 24 | One-cycle raise pulses, one bit per input pin |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted when high together with `msg_valid` |
| msg_vector | output | 8 | Interrupt vector |
| msg_dlv_mode | output | 3 | Delivery mode |
| msg_dst_logical | output | 1 | 1 = logical destination, 0 = physical destination |
| msg_trigger | output | 1 | Trigger mode bit |
| msg_dest | output | 8 | Destination field |
| msg_shorthand | output | 2 | Destination shorthand, always 0 |

## Verification
The bench aims at four corner cases.

- **Protected status bits.** It writes all ones to a low half and reads it back. A design that let software write bits 12 and 14 would return 0xFFFFFFFF instead of 0xFFFFAFFF.
- **Table and index edges.** It drives indexes on both sides of the table's edge: the last high half at 0x3F and the first missing entry at 0x40. It also drives the undefined gap 0x03 to 0x0F. A decode that wraps the entry number or accepts the gap would alias another register, or let a stray write corrupt one.
- **Pin 0 steering.** It raises input 0 alone and then together with input 2. A missing steer would deliver entry 0's vector. A steer that fails to merge the two raises would deliver two messages.
- **Ordering under backpressure.** It holds `msg_ready` low while three pins are pending, then toggles it. Wrong ordering or a message that changes while stalled is caught by the scoreboard's order and by its held-value comparison.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Low-half bits owned by hardware: delivery status (12) and remote request (14)
  localparam logic [31:0] LO_HW_BITS = 32'h0000_5000;
  // Entry low half after reset: only the mask bit set
  localparam logic [31:0] LO_RESET   = 32'h0001_0000;
  localparam int unsigned MASK_BIT   = 16;
  localparam int unsigned ID_LSB     = 24;

  typedef struct packed {
    logic [7:0] dest;
    logic       trig;
    logic       dst_log;
    logic [2:0] mode;
    logic [7:0] vector;
  } route_msg_t;

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NPINS    = 24,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned ID_W     = 4,
  parameter logic [7:0]  VER_CODE = 8'h11,
  localparam int unsigned PIN_W   = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PIN_W-1:0]  lk_pin,
  output route_msg_t        lk_msg,
  output logic [NPINS-1:0]  mask_vec
);

  localparam logic [31:0] VER_VAL = {8'h00, 8'(NPINS - 1), 8'h00, VER_CODE};

  logic [31:0] idx_q, idx_d;
  logic [31:0] id_q, id_d;
  logic [31:0] arb_q, arb_d;
  logic [31:0] lo_q [NPINS];
  logic [31:0] lo_d [NPINS];
  logic [31:0] hi_q [NPINS];
  logic [31:0] hi_d [NPINS];

  logic        addr_is_idx, addr_is_win, win_we;
  logic        sel_id, sel_ver, sel_arb, sel_ent, ent_hi;
  logic [31:0] ent_off;
  logic [30:0] ent_num;
  logic [PIN_W-1:0] ent_pin;
  logic [31:0] win_val;
  logic [31:0] id_rst;

  // Address and index decode
  always_comb begin
    addr_is_idx = (bus_addr == ADDR_W'(0));
    addr_is_win = (bus_addr == ADDR_W'(16));
    win_we      = bus_we && addr_is_win;
    sel_id      = (idx_q == 32'd0);
    sel_ver     = (idx_q == 32'd1);
    sel_arb     = (idx_q == 32'd2);
    ent_off     = idx_q - 32'h10;
    ent_num     = ent_off[31:1];
    ent_hi      = ent_off[0];
    sel_ent     = (idx_q >= 32'h10) && (ent_num < 31'(NPINS));
    ent_pin     = ent_num[PIN_W-1:0];
    id_rst      = 32'(cfg_id) << ID_LSB;
  end

  // Next-state
  always_comb begin
    idx_d = (bus_we && addr_is_idx) ? bus_wdata : idx_q;
    id_d  = (win_we && sel_id)      ? bus_wdata : id_q;
    arb_d = (win_we && sel_arb)     ? bus_wdata : arb_q;
    for (int e = 0; e < NPINS; e++) begin
      lo_d[e] = lo_q[e];
      hi_d[e] = hi_q[e];
      if (win_we && sel_ent && (ent_pin == PIN_W'(e))) begin
        if (ent_hi) hi_d[e] = bus_wdata;
        else        lo_d[e] = (bus_wdata & ~LO_HW_BITS) | (lo_q[e] & LO_HW_BITS);
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      id_q  <= id_rst;
      arb_q <= '0;
      for (int e = 0; e < NPINS; e++) begin
        lo_q[e] <= LO_RESET;
        hi_q[e] <= '0;
      end
    end else begin
      idx_q <= idx_d;
      id_q  <= id_d;
      arb_q <= arb_d;
      for (int e = 0; e < NPINS; e++) begin
        lo_q[e] <= lo_d[e];
        hi_q[e] <= hi_d[e];
      end
    end
  end

  // Read path
  always_comb begin
    win_val = '0;
    if (sel_id)       win_val = id_q;
    else if (sel_ver) win_val = VER_VAL;
    else if (sel_arb) win_val = arb_q;
    else if (sel_ent) win_val = ent_hi ? hi_q[ent_pin] : lo_q[ent_pin];
    bus_rdata = '0;
    if (addr_is_idx)      bus_rdata = idx_q;
    else if (addr_is_win) bus_rdata = win_val;
  end

  // Lookup of the entry being served
  always_comb begin
    lk_msg.vector  = lo_q[lk_pin][7:0];
    lk_msg.mode    = lo_q[lk_pin][10:8];
    lk_msg.dst_log = lo_q[lk_pin][11];
    lk_msg.trig    = lo_q[lk_pin][15];
    lk_msg.dest    = hi_q[lk_pin][31:24];
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_mask
    assign mask_vec[g] = lo_q[g][MASK_BIT];
  end

endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb #(
  parameter int unsigned NPINS      = 24,
  parameter int unsigned STEER_SRC  = 0,
  parameter int unsigned STEER_DST  = 2,
  localparam int unsigned PIN_W     = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] raise,
  input  logic [NPINS-1:0] mask_vec,
  input  logic             take,
  output logic             pend_any,
  output logic [PIN_W-1:0] grant
);

  logic [NPINS-1:0] steered, set_vec, clr_vec, pend_q, pend_d;

  for (genvar p = 0; p < NPINS; p++) begin : g_steer
    if (p == STEER_SRC) begin : g_src
      assign steered[p] = 1'b0;
    end else if (p == STEER_DST) begin : g_dst
      assign steered[p] = raise[p] | raise[STEER_SRC];
    end else begin : g_plain
      assign steered[p] = raise[p];
    end
  end

  // Lowest pending pin wins
  always_comb begin
    grant = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (pend_q[i]) grant = PIN_W'(i);
    end
    pend_any = |pend_q;
  end

  always_comb begin
    set_vec        = steered & ~mask_vec;
    clr_vec        = '0;
    clr_vec[grant] = take;
    pend_d         = (pend_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned NPINS  = 24,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned ID_W   = 4,
  localparam int unsigned PIN_W = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  irq_raise,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_dlv_mode,
  output logic              msg_dst_logical,
  output logic              msg_trigger,
  output logic [7:0]        msg_dest,
  output logic [1:0]        msg_shorthand
);

  logic rst_meta, rst_sync_n;
  logic [NPINS-1:0] mask_vec;
  logic             pend_any, take;
  logic [PIN_W-1:0] grant;
  route_msg_t       lk_msg, msg_q, msg_d;
  logic             vld_q, vld_d;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  irq_route_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .ID_W(ID_W)) regs_i (
    .clk(clk), .rst_n(rst_sync_n), .cfg_id(cfg_id),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lk_pin(grant), .lk_msg(lk_msg), .mask_vec(mask_vec)
  );

  irq_route_arb #(.NPINS(NPINS)) arb_i (
    .clk(clk), .rst_n(rst_sync_n), .raise(irq_raise), .mask_vec(mask_vec),
    .take(take), .pend_any(pend_any), .grant(grant)
  );

  // Message stage next-state
  always_comb begin
    take  = pend_any && (!vld_q || msg_ready);
    vld_d = vld_q;
    msg_d = msg_q;
    if (take) begin
      vld_d = 1'b1;
      msg_d = lk_msg;
    end else if (msg_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      msg_q <= '0;
    end else begin
      vld_q <= vld_d;
      msg_q <= msg_d;
    end
  end

  assign msg_valid       = vld_q;
  assign msg_vector      = msg_q.vector;
  assign msg_dlv_mode    = msg_q.mode;
  assign msg_dst_logical = msg_q.dst_log;
  assign msg_trigger     = msg_q.trig;
  assign msg_dest        = msg_q.dest;
  assign msg_shorthand   = 2'b00;

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [20:0]       msg_bits,
  input logic              pend_any
);

  // R10
  hold_msg_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_bits)));

  // R2
  idx_readback_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(bus_we) && ($past(bus_addr) == ADDR_W'(0)) && (bus_addr == ADDR_W'(0)))
      |-> (bus_rdata == $past(bus_wdata)));

  // R2
  dead_offset_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !((bus_addr == ADDR_W'(0)) || (bus_addr == ADDR_W'(16))) |-> (bus_rdata == 32'd0));

  // R9
  msg_from_pend_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(msg_valid) |-> $past(pend_any));

  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pend_any && !msg_valid) |=> !msg_valid);

endmodule

bind irq_route_ctrl irq_route_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msg_valid(msg_valid),
  .msg_ready(msg_ready),
  .msg_bits({msg_dest, msg_trigger, msg_dst_logical, msg_dlv_mode, msg_vector}),
  .pend_any(pend_any)
);

// File: tb/irq_route_ctrl_tb_top.sv
module irq_route_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_id = 4'h5;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [23:0] irq_raise = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [7:0]  msg_vector;
  logic [2:0]  msg_dlv_mode;
  logic        msg_dst_logical;
  logic        msg_trigger;
  logic [7:0]  msg_dest;
  logic [1:0]  msg_shorthand;

  int errors = 0;
  int checks = 0;
  int seen   = 0;
  int cycles = 0;

  logic [31:0] sh_lo [24];
  logic [31:0] sh_hi [24];
  logic [20:0] exp_q [$];

  always #5 clk = ~clk;

  irq_route_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_id(cfg_id), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_raise(irq_raise),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dlv_mode(msg_dlv_mode), .msg_dst_logical(msg_dst_logical),
    .msg_trigger(msg_trigger), .msg_dest(msg_dest), .msg_shorthand(msg_shorthand)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] fields_of(input int p);
    return {sh_hi[p][31:24], sh_lo[p][15], sh_lo[p][11], sh_lo[p][10:8], sh_lo[p][7:0]};
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic reg_wr(input logic [31:0] idx, input logic [31:0] d);
    bus_write(8'h00, idx);
    bus_write(8'h10, d);
    if (idx >= 32'h10 && ((idx - 32'h10) >> 1) < 24) begin
      if (idx[0]) sh_hi[(idx - 32'h10) >> 1] = d;
      else sh_lo[(idx - 32'h10) >> 1] = (d & ~32'h5000) | (sh_lo[(idx - 32'h10) >> 1] & 32'h5000);
    end
  endtask

  task automatic reg_chk(input logic [31:0] idx, input logic [31:0] exp, input string req);
    logic [31:0] v;
    bus_write(8'h00, idx);
    bus_read(8'h10, v);
    check(v == exp, req, v, exp);
  endtask

  // Driver: predict messages, then pulse the pins
  task automatic raise_pins(input logic [23:0] m);
    logic [23:0] st;
    st = m;
    st[0] = 1'b0;
    st[2] = m[2] | m[0];
    for (int p = 0; p < 24; p++)
      if (st[p] && !sh_lo[p][16]) exp_q.push_back(fields_of(p));
    @(negedge clk);
    irq_raise = m;
    @(negedge clk);
    irq_raise = '0;
  endtask

  task automatic drain(input string req);
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 300) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // Monitor / scoreboard
  logic        prev_stall = 1'b0;
  logic [20:0] prev_bits = '0;
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (prev_stall) begin
        // R10: held while stalled
        check(msg_valid && ({msg_dest, msg_trigger, msg_dst_logical, msg_dlv_mode, msg_vector} == prev_bits),
              "R10", {11'd0, msg_dest, msg_trigger, msg_dst_logical, msg_dlv_mode, msg_vector}, {11'd0, prev_bits});
      end
      prev_stall = msg_valid && !msg_ready;
      prev_bits  = {msg_dest, msg_trigger, msg_dst_logical, msg_dlv_mode, msg_vector};
      if (msg_valid && msg_ready) begin
        seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected message", {11'd0, prev_bits}, 32'd0);
        end else begin
          logic [20:0] e;
          e = exp_q.pop_front();
          check(prev_bits == e, "R7/R9 message", {11'd0, prev_bits}, {11'd0, e});
          check(msg_shorthand == 2'b00, "R7 shorthand", {30'd0, msg_shorthand}, 32'd0);
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int s0;
    for (int p = 0; p < 24; p++) begin sh_lo[p] = 32'h0001_0000; sh_hi[p] = 32'h0; end
    repeat (5) @(negedge clk);
    check(msg_valid == 1'b0, "R1 valid in reset", {31'd0, msg_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    check(msg_valid == 1'b0, "R1 valid", {31'd0, msg_valid}, 0);
    reg_chk(32'h1, 32'h0017_0011, "R1 version");
    reg_chk(32'h0, 32'h0500_0000, "R1 id");
    reg_chk(32'h2, 32'h0, "R1 arb");
    for (int p = 0; p < 24; p++) begin
      reg_chk(32'h10 + 2*p, 32'h0001_0000, "R1 entry low");
      reg_chk(32'h11 + 2*p, 32'h0, "R1 entry high");
    end

    // R2 index register and dead offsets
    bus_write(8'h00, 32'h0000_0012);
    bus_read(8'h00, v);
    check(v == 32'h12, "R2 index readback", v, 32'h12);
    bus_read(8'h04, v);
    check(v == 32'h0, "R2 dead offset read", v, 0);
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_read(8'h00, v);
    check(v == 32'h12, "R2 dead offset write", v, 32'h12);
    reg_chk(32'h12, 32'h0001_0000, "R2 dead offset write entry");

    // R3 / R4 window decode and write rules
    reg_wr(32'h1, 32'hFFFF_FFFF);
    reg_chk(32'h1, 32'h0017_0011, "R4 version read-only");
    reg_wr(32'h0, 32'hA5A5_0001);
    reg_chk(32'h0, 32'hA5A5_0001, "R4 id write");
    reg_wr(32'h2, 32'h0F00_0003);
    reg_chk(32'h2, 32'h0F00_0003, "R4 arb write");
    reg_chk(32'h0, 32'hA5A5_0001, "R3 id unaffected by arb");

    // R5 protected status bits
    reg_wr(32'h18, 32'hFFFF_FFFF);
    reg_chk(32'h18, 32'hFFFF_AFFF, "R5 low half keeps bits 12,14");
    reg_wr(32'h19, 32'hDEAD_BEEF);
    reg_chk(32'h19, 32'hDEAD_BEEF, "R5 high half full");
    reg_chk(32'h1A, 32'h0001_0000, "R3 neighbour entry untouched");

    // R6 edges of the table and undefined indexes
    reg_wr(32'h3F, 32'h1234_5678);
    reg_chk(32'h3F, 32'h1234_5678, "R6 last entry high");
    reg_wr(32'h40, 32'hFFFF_FFFF);
    reg_chk(32'h40, 32'h0, "R6 entry 24 reads zero");
    reg_chk(32'h10, 32'h0001_0000, "R6 entry 24 write no alias");
    reg_wr(32'h05, 32'hFFFF_FFFF);
    reg_chk(32'h05, 32'h0, "R6 undefined index");
    reg_chk(32'h0, 32'hA5A5_0001, "R6 undefined write no effect");

    // R7 unmasked and masked raises
    reg_wr(32'h1A, 32'h0000_8B31);
    reg_wr(32'h1B, 32'h7700_0000);
    s0 = seen;
    raise_pins(24'h1 << 5);
    drain("R7 single message");
    check(seen == s0 + 1, "R7 count", seen, s0 + 1);
    reg_wr(32'h1C, 32'h0001_0042);
    s0 = seen;
    raise_pins(24'h1 << 6);
    repeat (10) @(negedge clk);
    check(seen == s0, "R7 masked no message", seen, s0);

    // R8 steering of input 0
    reg_wr(32'h10, 32'h0000_0099);
    reg_wr(32'h14, 32'h0000_0120);
    reg_wr(32'h15, 32'h0200_0000);
    s0 = seen;
    raise_pins(24'h1);
    drain("R8 input 0 to pin 2");
    check(seen == s0 + 1, "R8 count", seen, s0 + 1);
    s0 = seen;
    raise_pins(24'h5);
    drain("R8 merged raise");
    check(seen == s0 + 1, "R8 merged count", seen, s0 + 1);

    // R9 / R10 ordering under backpressure
    reg_wr(32'h22, 32'h0000_0209);  reg_wr(32'h23, 32'h0900_0000);
    reg_wr(32'h28, 32'h0000_080C);  reg_wr(32'h29, 32'h0C00_0000);
    reg_wr(32'h38, 32'h0000_8414);  reg_wr(32'h39, 32'h1400_0000);
    @(negedge clk);
    msg_ready = 1'b0;
    raise_pins((24'h1 << 20) | (24'h1 << 9) | (24'h1 << 12));
    repeat (6) @(negedge clk);
    #1;
    check(msg_valid && msg_vector == 8'h09, "R9 lowest first held", {24'd0, msg_vector}, 32'h09);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      msg_ready = k[0];
    end
    msg_ready = 1'b1;
    drain("R9 ordered drain");

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule